// File: doc/BRIEF.md
# Ping-Pong Capture Buffer Controller

The controller steers an incoming stream of 128-byte data blocks into two memory buffers that take turns. Each buffer has a base address, and both share a line stride, a line length in bursts and a buffer length in blocks. For every accepted block the controller issues one burst write address. When a buffer has taken its configured number of blocks, the controller raises that buffer's full flag and moves on to the other buffer. Software services a full buffer in two steps. It first writes the buffer's base register and then clears the flag. Clearing the flag is what makes the buffer usable again.

Four control strobes drive the sequencing: start, record, stop and line. Each strobe has its own polarity bit and acts only on a genuine edge, meaning the inactive level must be sampled on the clock before the active level. Capture ends cleanly in two steps. Software clears one buffer's enable in one full interrupt and the other buffer's enable in the next. The controller goes idle when it finishes a buffer and finds the other buffer disabled.

Top module: `pp_capture_ctrl`

## Requirements
- R1: After synchronous reset, busy=0, full_irq=00, overflow=0, wr_valid=0 and both enables are clear. A block presented while idle produces no write.
- R2: strobe_in bits are start (bit 0), record (bit 1), stop (bit 2) and line (bit 3). They are sampled on the rising clock. With CTRL polarity bit 4+index equal to 0, a strobe counts when it is sampled high after being sampled low on the previous clock. With that bit equal to 1, the sense is reversed. A level held for several clocks counts once. The strobe's effect shows on the second clock edge after the first active sample.
- R3: CTRL is register offset 0. Bit 0 enables buffer A and bit 1 enables buffer B. A start strobe while idle with at least one enable set makes busy=1 and selects buffer A if A is enabled, otherwise buffer B. The selected buffer begins at the current value of its base register. Start has no effect when no enable is set. Blocks arriving before the record strobe are not written.
- R4: While capturing, each cycle with blk_valid=1 produces, on the next cycle, wr_valid=1, wr_addr = line start + 128 × position within the line, and wr_buf (0 = A, 1 = B). After LINE_LEN blocks (offset 4), the line start advances by STRIDE (offset 3) and the position returns to 0.
- R5: Bits [6:0] of base A (offset 1), base B (offset 2) and STRIDE are ignored, so every write address is 128-byte aligned.
- R6: After BUF_LEN blocks (offset 5), the buffer's full_irq bit (bit 0 = A, bit 1 = B) is set on the same edge that the last write appears. The next block goes to the other buffer if that buffer is enabled.
- R7: Writing 1 to bit 0 or bit 1 of STATUS (offset 6) clears that buffer's full flag and latches the buffer's base register. A base write made at any other time does not change the addresses used when the controller switches into that buffer. A flag stays set until it is cleared.
- R8: If the controller switches into a buffer whose full flag is still set, incoming blocks are dropped and overflow is set. overflow stays set until software writes 1 to STATUS bit 2. Clearing the blocked buffer's flag restarts that buffer at the newly written base.
- R9: When a buffer completes and the other buffer's enable is clear, busy falls on the same edge as the last write. Later blocks are not written.
- R10: A stop strobe returns the controller to idle from both the armed state and the capturing state. Later blocks are not written.
- R11: A line strobe in the middle of a line moves to the next line start (line start + stride). A line strobe at position 0 has no effect.
- R12: A STATUS write that clears the other buffer's flag on the same edge that the current buffer completes lets the switch go ahead with no overflow. The switch then uses the base that was just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | DW | Register write data |
| strobe_in | input | 4 | Start, record, stop and line strobes |
| blk_valid | input | 1 | One 128-byte block is ready |
| wr_valid | output | 1 | Burst write request |
| wr_addr | output | DW | Burst start address |
| wr_buf | output | 1 | Buffer written (0 = A, 1 = B) |
| full_irq | output | 2 | Full flags (bit 0 = A, bit 1 = B) |
| overflow | output | 1 | Sticky flag for dropped blocks |
| busy | output | 1 | Controller is armed or capturing |

## Verification
Two events can land on the same edge: the current buffer taking its final block, and software clearing the other buffer's full flag. The bench provokes this by raising blk_valid and a STATUS clear write on the same clock. It then judges the result at the ports. The last write must appear, the finished buffer's flag must rise while the other buffer's flag falls, overflow must stay low, and the next block must land at the base that was written just before the clear.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int NSTB        = 4;
  localparam int STB_START   = 0;
  localparam int STB_REC     = 1;
  localparam int STB_STOP    = 2;
  localparam int STB_LINE    = 3;
  localparam int POL_LSB     = 4;
  localparam int BURST_SHIFT = 7;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_BASE_A = 3'd1;
  localparam logic [2:0] REG_BASE_B = 3'd2;
  localparam logic [2:0] REG_STRIDE = 3'd3;
  localparam logic [2:0] REG_LINE   = 3'd4;
  localparam logic [2:0] REG_BUFLEN = 3'd5;
  localparam logic [2:0] REG_STATUS = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_CAPT} cap_state_t;
endpackage

// File: rtl/pp_strobe_edge.sv
module pp_strobe_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] pol,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_stb
    logic samp_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        samp_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        samp_q <= raw[i];
        prev_q <= samp_q;
      end
    end
    assign pulse[i] = pol[i] ? (prev_q & ~samp_q) : (samp_q & ~prev_q);

    // R2: one strobe edge gives a single-cycle pulse unless polarity changes
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
      pulse[i] |=> (!pulse[i] || (pol[i] != $past(pol[i]))));
  end
endmodule

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs
  import pp_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [2:0]          addr,
  input  logic [DW-1:0]       wdata,
  output logic [1:0]          en,
  output logic [NSTB-1:0]     pol,
  output logic [1:0][DW-1:0]  base,
  output logic [DW-1:0]       stride,
  output logic [CW-1:0]       line_len,
  output logic [CW-1:0]       buf_len,
  output logic [1:0]          clr_full,
  output logic                clr_ovf
);
  localparam logic [BURST_SHIFT-1:0] ZERO_LOW = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= '0;
      pol      <= '0;
      base     <= '0;
      stride   <= '0;
      line_len <= CW'(1);
      buf_len  <= CW'(1);
    end else if (we) begin
      case (addr)
        REG_CTRL: begin
          en  <= wdata[1:0];
          pol <= wdata[POL_LSB +: NSTB];
        end
        REG_BASE_A: base[0]  <= {wdata[DW-1:BURST_SHIFT], ZERO_LOW};
        REG_BASE_B: base[1]  <= {wdata[DW-1:BURST_SHIFT], ZERO_LOW};
        REG_STRIDE: stride   <= {wdata[DW-1:BURST_SHIFT], ZERO_LOW};
        REG_LINE:   line_len <= wdata[CW-1:0];
        REG_BUFLEN: buf_len  <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  assign clr_full = (we && addr == REG_STATUS) ? wdata[1:0] : 2'b00;
  assign clr_ovf  = we && (addr == REG_STATUS) && wdata[2];
endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSTB-1:0]     pulse,
  input  logic                blk_valid,
  input  logic [1:0]          en,
  input  logic [1:0][DW-1:0]  base,
  input  logic [DW-1:0]       stride,
  input  logic [CW-1:0]       line_len,
  input  logic [CW-1:0]       buf_len,
  input  logic [1:0]          clr_full,
  input  logic                clr_ovf,
  output logic                wr_valid,
  output logic [DW-1:0]       wr_addr,
  output logic                wr_buf,
  output logic [1:0]          full_irq,
  output logic                overflow,
  output logic                busy
);
  cap_state_t st_q, st_d;
  logic               cur_q, cur_d;
  logic [DW-1:0]      lb_q, lb_d;
  logic [CW-1:0]      bil_q, bil_d, cnt_q, cnt_d;
  logic [1:0][DW-1:0] act_q;
  logic [1:0]         full_q, set_full;
  logic               ovf_q, ovf_set, accept, load_all;
  logic [DW-1:0]      pos_addr;

  assign pos_addr = lb_q + (DW'(bil_q) << BURST_SHIFT);

  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    lb_d     = lb_q;
    bil_d    = bil_q;
    cnt_d    = cnt_q;
    set_full = 2'b00;
    ovf_set  = 1'b0;
    accept   = 1'b0;
    load_all = 1'b0;
    if (pulse[STB_STOP]) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (pulse[STB_START] && (en != 2'b00)) begin
          load_all = 1'b1;
          st_d     = ST_ARMED;
          cur_d    = ~en[0];
          lb_d     = base[~en[0]];
          bil_d    = '0;
          cnt_d    = '0;
        end
        ST_ARMED: if (pulse[STB_REC]) st_d = ST_CAPT;
        default: begin
          if (full_q[cur_q]) begin
            ovf_set = blk_valid;
            if (clr_full[cur_q]) begin
              lb_d  = base[cur_q];
              bil_d = '0;
              cnt_d = '0;
            end
          end else if (blk_valid) begin
            accept = 1'b1;
            cnt_d  = cnt_q + CW'(1);
            if (bil_q + CW'(1) >= line_len) begin
              lb_d  = lb_q + stride;
              bil_d = '0;
            end else begin
              bil_d = bil_q + CW'(1);
            end
            if (cnt_q + CW'(1) >= buf_len) begin
              set_full[cur_q] = 1'b1;
              cnt_d = '0;
              bil_d = '0;
              if (en[~cur_q]) begin
                cur_d = ~cur_q;
                lb_d  = (clr_full[~cur_q] && full_q[~cur_q]) ? base[~cur_q] : act_q[~cur_q];
              end else begin
                st_d = ST_IDLE;
              end
            end
          end else if (pulse[STB_LINE] && (bil_q != '0)) begin
            lb_d  = lb_q + stride;
            bil_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cur_q    <= 1'b0;
      lb_q     <= '0;
      bil_q    <= '0;
      cnt_q    <= '0;
      act_q    <= '0;
      full_q   <= '0;
      ovf_q    <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_buf   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_q    <= cur_d;
      lb_q     <= lb_d;
      bil_q    <= bil_d;
      cnt_q    <= cnt_d;
      full_q   <= (full_q & ~clr_full) | set_full;
      ovf_q    <= (ovf_q & ~clr_ovf) | ovf_set;
      wr_valid <= accept;
      if (accept) begin
        wr_addr <= pos_addr;
        wr_buf  <= cur_q;
      end
      if (load_all) begin
        act_q <= base;
      end else begin
        for (int i = 0; i < 2; i++)
          if (clr_full[i] && full_q[i]) act_q[i] <= base[i];
      end
    end
  end

  assign full_irq = full_q;
  assign overflow = ovf_q;
  assign busy     = (st_q != ST_IDLE);

  for (genvar i = 0; i < 2; i++) begin : g_flag_chk
    // R6: a full flag rises only together with that buffer's final write
    a_r6_flag_with_write: assert property (@(posedge clk) disable iff (rst)
      $rose(full_q[i]) |-> (wr_valid && (wr_buf == i[0])));
    // R7: a full flag is held until software clears it
    a_r7_flag_held: assert property (@(posedge clk) disable iff (rst)
      (full_q[i] && !clr_full[i]) |=> full_q[i]);
  end

  // R5: every burst address is 128-byte aligned
  a_r5_aligned: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr[BURST_SHIFT-1:0] == '0));
  // R8: overflow is sticky until its clear bit is written
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_ovf) |=> ovf_q);
  // R10: a stop strobe always leaves the controller idle
  a_r10_stop_idles: assert property (@(posedge clk) disable iff (rst)
    pulse[STB_STOP] |=> !busy);
  // R3: writes only come out of the capturing state
  a_r3_write_from_capture: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ($past(st_q) == ST_CAPT));
endmodule

// File: rtl/pp_capture_ctrl.sv
module pp_capture_ctrl
  import pp_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [NSTB-1:0] strobe_in,
  input  logic            blk_valid,
  output logic            wr_valid,
  output logic [DW-1:0]   wr_addr,
  output logic            wr_buf,
  output logic [1:0]      full_irq,
  output logic            overflow,
  output logic            busy
);
  logic [1:0]          en, clr_full;
  logic [NSTB-1:0]     pol, pulse;
  logic [1:0][DW-1:0]  base;
  logic [DW-1:0]       stride;
  logic [CW-1:0]       line_len, buf_len;
  logic                clr_ovf;

  pp_cfg_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .pol(pol), .base(base), .stride(stride),
    .line_len(line_len), .buf_len(buf_len), .clr_full(clr_full), .clr_ovf(clr_ovf)
  );

  pp_strobe_edge #(.N(NSTB)) u_edge (
    .clk(clk), .rst(rst), .raw(strobe_in), .pol(pol), .pulse(pulse)
  );

  pp_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .pulse(pulse), .blk_valid(blk_valid),
    .en(en), .base(base), .stride(stride), .line_len(line_len), .buf_len(buf_len),
    .clr_full(clr_full), .clr_ovf(clr_ovf),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_buf(wr_buf),
    .full_irq(full_irq), .overflow(overflow), .busy(busy)
  );
endmodule

// File: tb/tb_pp_capture_ctrl.sv
`timescale 1ns/1ps
module tb_pp_capture_ctrl;
  localparam int DW = 32;
  localparam logic [2:0] O_CTRL = 3'd0, O_BA = 3'd1, O_BB = 3'd2, O_STR = 3'd3,
                         O_LINE = 3'd4, O_BUF = 3'd5, O_STAT = 3'd6;
  localparam int S_START = 0, S_REC = 1, S_STOP = 2, S_LINE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [3:0]    strobe_in = '0;
  logic          blk_valid = 1'b0;
  logic          wr_valid, wr_buf, overflow, busy;
  logic [DW-1:0] wr_addr;
  logic [1:0]    full_irq;
  int checks = 0;
  int errors = 0;

  pp_capture_ctrl #(.DW(DW), .CW(16)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .strobe_in(strobe_in), .blk_valid(blk_valid), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_buf(wr_buf), .full_irq(full_irq), .overflow(overflow), .busy(busy)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_addr(logic [DW-1:0] b, logic [DW-1:0] s, int ll, int k);
    return (b & ~32'h7F) + 32'(k / ll) * (s & ~32'h7F) + 32'((k % ll) * 128);
  endfunction

  task automatic cfg_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic strobe(input int idx);
    @(negedge clk); strobe_in[idx] = 1'b1;
    @(negedge clk); strobe_in[idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_blk();
    @(negedge clk); blk_valid = 1'b1;
    @(negedge clk); blk_valid = 1'b0;
  endtask

  task automatic expect_wr(input string req, input logic [DW-1:0] a, input logic b);
    send_blk();
    check({req, " wr_valid"}, 32'(wr_valid), 32'd1);
    check({req, " wr_addr"}, wr_addr, a);
    check({req, " wr_buf"}, 32'(wr_buf), 32'(b));
  endtask

  task automatic expect_drop(input string req);
    send_blk();
    check({req, " no write"}, 32'(wr_valid), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 full", 32'(full_irq), 0);
    check("R1 ovf", 32'(overflow), 0);
    check("R1 wr_valid", 32'(wr_valid), 0);
    expect_drop("R1 idle block");
    strobe(S_START);
    check("R3 start without enable", 32'(busy), 0);

    cfg_wr(O_BA, 32'h1000_0055);
    cfg_wr(O_BB, 32'h2000_0000);
    cfg_wr(O_STR, 32'h0000_043F);
    cfg_wr(O_LINE, 3);
    cfg_wr(O_BUF, 7);
    cfg_wr(O_CTRL, 3);
    strobe(S_START);
    check("R3 armed", 32'(busy), 1);
    expect_drop("R3 armed block");
    strobe(S_REC);
    for (int k = 0; k < 7; k++) begin
      if (k == 6) check("R6 not yet full", 32'(full_irq), 0);
      expect_wr("R4 R5 buffer A", exp_addr(32'h1000_0055, 32'h43F, 3, k), 1'b0);
    end
    check("R6 A full", 32'(full_irq), 32'b01);

    cfg_wr(O_BA, 32'h3000_0000);
    for (int k = 0; k < 7; k++)
      expect_wr("R6 buffer B", exp_addr(32'h2000_0000, 32'h400, 3, k), 1'b1);
    check("R6 both full", 32'(full_irq), 32'b11);
    expect_drop("R8 blocked buffer");
    check("R8 ovf set", 32'(overflow), 1);
    cfg_wr(O_STAT, 1);
    check("R7 A cleared", 32'(full_irq), 32'b10);
    expect_wr("R8 restart at new base", 32'h3000_0000, 1'b0);
    check("R8 ovf sticky", 32'(overflow), 1);
    cfg_wr(O_STAT, 4);
    check("R8 ovf cleared", 32'(overflow), 0);

    cfg_wr(O_STAT, 2);
    cfg_wr(O_BB, 32'h4000_0000);
    for (int k = 1; k < 7; k++)
      expect_wr("R7 new A base", exp_addr(32'h3000_0000, 32'h400, 3, k), 1'b0);
    check("R7 A full", 32'(full_irq), 32'b01);
    expect_wr("R7 latched B base", 32'h2000_0000, 1'b1);

    cfg_wr(O_BA, 32'h5000_0000);
    for (int k = 1; k < 6; k++)
      expect_wr("R4 buffer B", exp_addr(32'h2000_0000, 32'h400, 3, k), 1'b1);
    // R12: last block of B and clear of A flag on the same edge
    @(negedge clk);
    blk_valid = 1'b1; cfg_we = 1'b1; cfg_addr = O_STAT; cfg_wdata = 32'd1;
    @(negedge clk);
    blk_valid = 1'b0; cfg_we = 1'b0;
    check("R12 last write", 32'(wr_valid), 1);
    check("R12 last addr", wr_addr, exp_addr(32'h2000_0000, 32'h400, 3, 6));
    check("R12 flags", 32'(full_irq), 32'b10);
    check("R12 no overflow", 32'(overflow), 0);
    expect_wr("R12 switch to new base", 32'h5000_0000, 1'b0);

    strobe(S_LINE);
    expect_wr("R11 mid-line strobe", 32'h5000_0400, 1'b0);
    expect_wr("R4 line", 32'h5000_0480, 1'b0);
    expect_wr("R4 line", 32'h5000_0500, 1'b0);
    strobe(S_LINE);
    expect_wr("R11 strobe at line start", 32'h5000_0800, 1'b0);

    cfg_wr(O_CTRL, 1);
    cfg_wr(O_STAT, 2);
    expect_wr("R4 line", 32'h5000_0880, 1'b0);
    expect_wr("R9 final write", 32'h5000_0900, 1'b0);
    check("R9 idle", 32'(busy), 0);
    check("R9 A full", 32'(full_irq), 32'b01);
    expect_drop("R9 after idle");
    cfg_wr(O_CTRL, 0);
    cfg_wr(O_STAT, 7);

    cfg_wr(O_CTRL, 1);
    strobe(S_START);
    strobe(S_REC);
    expect_wr("R10 capture", 32'h5000_0000, 1'b0);
    strobe(S_STOP);
    check("R10 stopped", 32'(busy), 0);
    expect_drop("R10 after stop");

    cfg_wr(O_CTRL, 2);
    strobe(S_START);
    strobe(S_REC);
    expect_wr("R3 B first", 32'h4000_0000, 1'b1);
    strobe(S_STOP);

    cfg_wr(O_CTRL, 32'h11);
    @(negedge clk); strobe_in[S_START] = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 rising ignored when falling", 32'(busy), 0);
    strobe_in[S_START] = 1'b0;
    @(negedge clk);
    check("R2 latency", 32'(busy), 0);
    @(negedge clk);
    check("R2 falling edge starts", 32'(busy), 1);
    strobe(S_STOP);
    cfg_wr(O_CTRL, 1);
    @(negedge clk); strobe_in[S_START] = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 rising starts", 32'(busy), 1);
    strobe(S_STOP);
    repeat (3) @(negedge clk);
    check("R2 held level no retrigger", 32'(busy), 0);
    strobe_in[S_START] = 1'b0;
    cfg_wr(O_STAT, 7);

    for (int r = 0; r < 20; r++) begin
      logic [DW-1:0] ba, bb, st;
      int ll, bl;
      ba = $urandom();
      bb = $urandom();
      st = $urandom() % 8192;
      ll = 1 + int'($urandom() % 4);
      bl = 1 + int'($urandom() % 6);
      cfg_wr(O_STAT, 7);
      cfg_wr(O_BA, ba);
      cfg_wr(O_BB, bb);
      cfg_wr(O_STR, st);
      cfg_wr(O_LINE, 32'(ll));
      cfg_wr(O_BUF, 32'(bl));
      cfg_wr(O_CTRL, 3);
      strobe(S_START);
      strobe(S_REC);
      for (int k = 0; k < bl; k++)
        expect_wr("R4 R5 random", exp_addr(ba, st, ll, k), 1'b0);
      check("R6 random full", 32'(full_irq), 32'b01);
      expect_wr("R6 random switch", bb & ~32'h7F, 1'b1);
      strobe(S_STOP);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule